// File: doc/BRIEF.md
# Oversampling Serial Receiver with Parity Filtering

This block turns an asynchronous serial input line into 8-bit characters. The line passes through a two-stage synchronizer and is watched with a tick that runs 16 times faster than the bit rate. Each character is a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one stop bit. Every bit is sampled once, in the middle of its window.

A 3-bit mode field chooses how the parity bit is handled. The receiver can ignore it, check it, or use it as a filter that silently drops characters of one parity. An all-zero character whose stop bit is also low is reported as a break, not as a frame error. Accepted bytes leave on a valid/ready stream that feeds an external receive FIFO. Parity error, frame error, break and FIFO flush are one-cycle pulses. A synchronous soft reset returns the receiver to idle and flushes the FIFO.

Top module: `uart_rx_filter`

## Requirements
- R1: The oversampling tick fires once every `div`+1 clock cycles. A bit lasts 16 ticks and is sampled at its 8th tick. Characters sent with bit periods of 16×(`div`+1) cycles are received correctly for each `div` value.
- R2: A falling edge on the line starts a character only if the line is still low at the middle of the start bit. If it is high there, the receiver returns to idle and produces no output.
- R3: The eight data bits are assembled least significant bit first. When `mode`[2:1] is 00, no parity bit is expected and `mode`[0] has no effect.
- R4: In mode 010, a character whose parity bit is 1 is discarded. In mode 011, a character whose parity bit is 0 is discarded. A discarded character is not sent on the stream and raises no parity error pulse. Characters of the other parity are delivered.
- R5: Mode 100 checks even parity and mode 101 checks odd parity, both over the data and parity bits together. Mode 110 expects a parity bit of 0 and mode 111 expects a parity bit of 1. On a mismatch, `par_err` pulses for one cycle and the byte is still delivered.
- R6: A stop bit sampled low pulses `frm_err` for one cycle, and the byte is still delivered, unless the character is a break.
- R7: A break is a character whose data bits, parity bit (if any) and stop bit are all 0. A break pulses `brk` for one cycle. It delivers no byte and raises neither `frm_err` nor `par_err`.
- R8: After a character whose stop bit was low, no new start bit is taken until the line has been seen high.
- R9: While `rx_en` is low, no new character is started.
- R10: When `soft_rst` is high, the receiver goes to idle on the next edge and any byte waiting on the stream is dropped. `flush` pulses for one cycle in the following cycle.
- R11: While `byte_valid` is high and `byte_ready` is low, `byte_data` holds steady. A character that completes while a byte is still waiting is discarded.
- R12: After reset, `byte_valid`, `par_err`, `frm_err`, `brk` and `flush` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Allows new characters to start |
| soft_rst | input | 1 | Synchronous receiver reset and FIFO flush request |
| mode | input | 3 | Parity mode (see R3 to R5) |
| div | input | 9 | Tick divisor; tick period is div+1 cycles |
| rxd | input | 1 | Asynchronous serial input line, idle high |
| byte_valid | output | 1 | Received byte is available |
| byte_ready | input | 1 | Downstream FIFO accepts the byte |
| byte_data | output | 8 | Received byte |
| par_err | output | 1 | One-cycle parity error pulse |
| frm_err | output | 1 | One-cycle frame error pulse |
| brk | output | 1 | One-cycle break pulse |
| flush | output | 1 | One-cycle FIFO flush pulse |

## Verification
The table sends characters in every parity mode, with the parity bit set both ways, so that a check, a filter drop and a clean delivery can each be told apart. It also varies the divisor, which exposes sampling that is not tied to the bit middle. All-zero characters with a low stop bit are sent with and without a matching zero parity bit, which separates a break from a frame error combined with a parity error. Directed cases cover a short start glitch, a held-low line after a break, a low enable, a soft reset in the middle of a character, and a stalled stream receiving a second character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  localparam logic [2:0] MODE_DROP_ONE  = 3'b010;
  localparam logic [2:0] MODE_DROP_ZERO = 3'b011;
  localparam logic [2:0] MODE_EVEN      = 3'b100;
  localparam logic [2:0] MODE_ODD       = 3'b101;
  localparam logic [2:0] MODE_STUCK0    = 3'b110;
  localparam logic [2:0] MODE_STUCK1    = 3'b111;

  function automatic logic mode_has_parity(input logic [2:0] m);
    return m[2:1] != 2'b00;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic [2:0]        mode,
  input  logic              rxs,
  input  logic              tick,
  output logic              run,
  output logic              done,
  output logic [DATA_W-1:0] char_out,
  output logic              pe,
  output logic              fe,
  output logic              brk
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rx_state_e         state;
  logic [SUB_W-1:0]  sub;
  logic [BIT_W-1:0]  nbit;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              armed;

  logic is_brk, drop, perr;

  assign run      = state != ST_IDLE;
  assign char_out = shreg;

  always_comb begin
    is_brk = (shreg == '0) && (!mode_has_parity(mode) || !par_bit) && !rxs;
    drop   = ((mode == MODE_DROP_ONE) && par_bit) || ((mode == MODE_DROP_ZERO) && !par_bit);
    case (mode)
      MODE_EVEN:   perr = ^{shreg, par_bit};
      MODE_ODD:    perr = ~^{shreg, par_bit};
      MODE_STUCK0: perr = par_bit;
      MODE_STUCK1: perr = !par_bit;
      default:     perr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sub     <= '0;
      nbit    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      armed   <= 1'b0;
      done    <= 1'b0;
      pe      <= 1'b0;
      fe      <= 1'b0;
      brk     <= 1'b0;
    end else begin
      done <= 1'b0;
      pe   <= 1'b0;
      fe   <= 1'b0;
      brk  <= 1'b0;
      if (soft_rst) begin
        state <= ST_IDLE;
        sub   <= '0;
        armed <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (rxs) armed <= 1'b1;
            if (rx_en && armed && !rxs) begin
              state   <= ST_START;
              sub     <= '0;
              armed   <= 1'b0;
              par_bit <= 1'b0;
            end
          end
          ST_START: if (tick) begin
            if (sub == SUB_MID) begin
              sub   <= '0;
              nbit  <= '0;
              state <= rxs ? ST_IDLE : ST_DATA;
            end else sub <= sub + 1'b1;
          end
          ST_DATA: if (tick) begin
            if (sub == SUB_LAST) begin
              sub   <= '0;
              shreg <= {rxs, shreg[DATA_W-1:1]};
              nbit  <= nbit + 1'b1;
              if (nbit == BIT_LAST) state <= mode_has_parity(mode) ? ST_PAR : ST_STOP;
            end else sub <= sub + 1'b1;
          end
          ST_PAR: if (tick) begin
            if (sub == SUB_LAST) begin
              sub     <= '0;
              par_bit <= rxs;
              state   <= ST_STOP;
            end else sub <= sub + 1'b1;
          end
          ST_STOP: if (tick) begin
            if (sub == SUB_LAST) begin
              sub   <= '0;
              state <= ST_IDLE;
              armed <= rxs;
              brk   <= is_brk;
              fe    <= !is_brk && !rxs;
              pe    <= !is_brk && perr;
              done  <= !is_brk && !drop;
            end else sub <= sub + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !rx_en) |=> state == ST_IDLE);

  // R2
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && tick && sub == SUB_MID && rxs) |=> state == ST_IDLE);

  // R7
  brk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> (!fe && !pe && !done));

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && tick && sub == SUB_LAST && !rxs) |=> !armed && state == ST_IDLE);
endmodule

// File: rtl/uart_rx_filter.sv
module uart_rx_filter
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 9,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic [2:0]        mode,
  input  logic [DIV_W-1:0]  div,
  input  logic              rxd,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [DATA_W-1:0] byte_data,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk,
  output logic              flush
);
  logic              rxs, tick, run, done;
  logic [DATA_W-1:0] char_w;

  uart_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
  );

  uart_rx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst),
    .mode(mode), .rxs(rxs), .tick(tick), .run(run), .done(done),
    .char_out(char_w), .pe(par_err), .fe(frm_err), .brk(brk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      flush      <= 1'b0;
    end else begin
      flush <= soft_rst;
      if (soft_rst) begin
        byte_valid <= 1'b0;
      end else if (done && (!byte_valid || byte_ready)) begin
        byte_valid <= 1'b1;
        byte_data  <= char_w;
      end else if (byte_ready) begin
        byte_valid <= 1'b0;
      end
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready && !soft_rst) |=> (byte_valid && $stable(byte_data)));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flush && !byte_valid));

  // R5
  pe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(mode[2]));
endmodule

// File: tb/test_uart_rx_filter.sv
`timescale 1ns/1ps
module test_uart_rx_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       soft_rst = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [8:0] div = 9'd2;
  logic       rxd = 1'b1;
  logic       byte_ready = 1'b1;
  logic       byte_valid, par_err, frm_err, brk, flush;
  logic [7:0] byte_data;

  always #4 clk = ~clk;

  uart_rx_filter i_uart_rx_filter (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst),
    .mode(mode), .div(div), .rxd(rxd), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data), .par_err(par_err),
    .frm_err(frm_err), .brk(brk), .flush(flush)
  );

  int n_chk = 0, n_bad = 0;
  int n_wr = 0, n_pe = 0, n_fe = 0, n_brk = 0, n_fl = 0;
  logic [7:0] last_data = 8'h00;

  always @(negedge clk) if (rst_n) begin
    if (byte_valid && byte_ready) begin n_wr++; last_data = byte_data; end
    if (par_err) n_pe++;
    if (frm_err) n_fe++;
    if (brk)     n_brk++;
    if (flush)   n_fl++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bit_t();
    return 16 * (int'(div) + 1);
  endfunction

  task automatic send(input logic [7:0] d, input logic par, input logic stop, input int idle_bits);
    rxd = 1'b0; wait_cyc(bit_t());
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_cyc(bit_t()); end
    if (mode[2:1] != 2'b00) begin rxd = par; wait_cyc(bit_t()); end
    rxd = stop; wait_cyc(bit_t());
    if (idle_bits > 0) begin rxd = 1'b1; wait_cyc(idle_bits * bit_t()); end
  endtask

  // {div[1:0], mode, data, parity, stop, expect write, pe, fe, brk}
  localparam int NV = 21;
  localparam logic [18:0] VEC [NV] = '{
    {2'd2, 3'b000, 8'hA5, 1'b0, 1'b1, 4'b1000},  // R3 no parity
    {2'd2, 3'b001, 8'h3C, 1'b1, 1'b1, 4'b1000},  // R3 mode[0] ignored
    {2'd0, 3'b000, 8'h96, 1'b0, 1'b1, 4'b1000},  // R1 div 0
    {2'd3, 3'b000, 8'h81, 1'b0, 1'b1, 4'b1000},  // R1 div 3
    {2'd2, 3'b100, 8'h01, 1'b1, 1'b1, 4'b1000},  // R5 even ok
    {2'd2, 3'b100, 8'h01, 1'b0, 1'b1, 4'b1100},  // R5 even bad
    {2'd2, 3'b101, 8'h03, 1'b1, 1'b1, 4'b1000},  // R5 odd ok
    {2'd2, 3'b101, 8'h03, 1'b0, 1'b1, 4'b1100},  // R5 odd bad
    {2'd2, 3'b110, 8'h55, 1'b0, 1'b1, 4'b1000},  // R5 stuck0 ok
    {2'd2, 3'b110, 8'h55, 1'b1, 1'b1, 4'b1100},  // R5 stuck0 bad
    {2'd2, 3'b111, 8'hC3, 1'b1, 1'b1, 4'b1000},  // R5 stuck1 ok
    {2'd2, 3'b111, 8'hC3, 1'b0, 1'b1, 4'b1100},  // R5 stuck1 bad
    {2'd2, 3'b010, 8'h77, 1'b1, 1'b1, 4'b0000},  // R4 drop parity 1
    {2'd2, 3'b010, 8'h78, 1'b0, 1'b1, 4'b1000},  // R4 keep parity 0
    {2'd2, 3'b011, 8'h11, 1'b0, 1'b1, 4'b0000},  // R4 drop parity 0
    {2'd2, 3'b011, 8'h12, 1'b1, 1'b1, 4'b1000},  // R4 keep parity 1
    {2'd2, 3'b000, 8'h5A, 1'b0, 1'b0, 4'b1010},  // R6 frame error
    {2'd2, 3'b000, 8'h00, 1'b0, 1'b0, 4'b0001},  // R7 break no parity
    {2'd2, 3'b100, 8'h00, 1'b0, 1'b0, 4'b0001},  // R7 break with parity
    {2'd2, 3'b100, 8'h00, 1'b1, 1'b0, 4'b1110},  // R7 not break: pe+fe
    {2'd2, 3'b101, 8'h00, 1'b0, 1'b0, 4'b0001}   // R7 break beats odd error
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int w0, p0, f0, b0, l0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R12 reset state
    chk(!byte_valid && !par_err && !frm_err && !brk && !flush, "R12",
        {byte_valid, par_err, frm_err, brk, flush}, 0);
    rx_en = 1'b1;
    wait_cyc(4);

    for (int v = 0; v < NV; v++) begin
      div  = {7'd0, VEC[v][18:17]};
      mode = VEC[v][16:14];
      wait_cyc(2);
      w0 = n_wr; p0 = n_pe; f0 = n_fe; b0 = n_brk;
      send(VEC[v][13:6], VEC[v][5], VEC[v][4], 2);
      chk((n_wr - w0) == int'(VEC[v][3]), $sformatf("R4/R3 write v%0d", v), n_wr - w0, VEC[v][3]);
      if (VEC[v][3])
        chk(last_data == VEC[v][13:6], $sformatf("R3 data v%0d", v), last_data, VEC[v][13:6]);
      chk((n_pe - p0) == int'(VEC[v][2]), $sformatf("R5 par_err v%0d", v), n_pe - p0, VEC[v][2]);
      chk((n_fe - f0) == int'(VEC[v][1]), $sformatf("R6 frm_err v%0d", v), n_fe - f0, VEC[v][1]);
      chk((n_brk - b0) == int'(VEC[v][0]), $sformatf("R7 brk v%0d", v), n_brk - b0, VEC[v][0]);
    end

    div = 9'd2; mode = 3'b000;

    // R2 short start glitch
    w0 = n_wr; f0 = n_fe; b0 = n_brk;
    rxd = 1'b0; wait_cyc(4 * 3); rxd = 1'b1; wait_cyc(12 * bit_t());
    chk(n_wr == w0 && n_fe == f0 && n_brk == b0, "R2 glitch", n_wr - w0, 0);
    send(8'h6E, 1'b0, 1'b1, 2);
    chk(n_wr == w0 + 1 && last_data == 8'h6E, "R2 after glitch", last_data, 8'h6E);

    // R8 line held low after break
    w0 = n_wr; b0 = n_brk; f0 = n_fe;
    send(8'h00, 1'b0, 1'b0, 0);
    rxd = 1'b0; wait_cyc(14 * bit_t());
    rxd = 1'b1; wait_cyc(2 * bit_t());
    chk(n_brk == b0 + 1, "R8 single break", n_brk - b0, 1);
    chk(n_wr == w0 && n_fe == f0, "R8 no extra char", n_wr - w0, 0);

    // R9 enable low
    rx_en = 1'b0; w0 = n_wr;
    send(8'h42, 1'b0, 1'b1, 2);
    chk(n_wr == w0, "R9 disabled", n_wr - w0, 0);
    rx_en = 1'b1; wait_cyc(4);

    // R10 soft reset mid character
    w0 = n_wr; l0 = n_fl; f0 = n_fe;
    rxd = 1'b0; wait_cyc(bit_t());
    rxd = 1'b1; wait_cyc(2 * bit_t());
    soft_rst = 1'b1; wait_cyc(1); soft_rst = 1'b0;
    wait_cyc(12 * bit_t());
    chk(n_fl == l0 + 1, "R10 flush pulse", n_fl - l0, 1);
    chk(n_wr == w0 && n_fe == f0, "R10 no output", n_wr - w0, 0);
    send(8'h9D, 1'b0, 1'b1, 2);
    chk(n_wr == w0 + 1 && last_data == 8'h9D, "R10 recovers", last_data, 8'h9D);

    // R11 back-pressure
    byte_ready = 1'b0; w0 = n_wr;
    send(8'h11, 1'b0, 1'b1, 1);
    send(8'h22, 1'b0, 1'b1, 1);
    chk(byte_valid && byte_data == 8'h11, "R11 held byte", byte_data, 8'h11);
    byte_ready = 1'b1; wait_cyc(3);
    chk(n_wr == w0 + 1 && last_data == 8'h11, "R11 one delivered", n_wr - w0, 1);
    chk(!byte_valid, "R11 second dropped", byte_valid, 0);

    // R10 soft reset drops waiting byte
    byte_ready = 1'b0;
    send(8'h33, 1'b0, 1'b1, 1);
    chk(byte_valid, "R10 byte waiting", byte_valid, 1);
    soft_rst = 1'b1; wait_cyc(1); soft_rst = 1'b0; wait_cyc(1);
    chk(!byte_valid, "R10 byte dropped", byte_valid, 0);
    byte_ready = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule